// File: doc/BRIEF.md
# Clock Output Distribution Controller

This block manages a bank of clock output channels (four by default) from a small byte-wide register interface. Software writes a power-down word, an enable word and one mode byte per channel. From these the block drives, for every channel, a power-down line, an enable line for the channel's divider and the pin-function controls of its output stage. It also drives a receiver-select line for the clock input. When every channel is powered down, the block raises a single deep-sleep line for the whole distribution section.

Enables do not reach the dividers the moment they are written. They are staged and copied to the channel enable lines only on a common alignment pulse from the divider bank. All channels therefore turn on or off on the same edge. Channels with equal ratios stay phase-aligned and no channel emits a shortened pulse. Each channel's 3-bit mode code is decoded into a drive enable for the positive pin, a drive enable for the negative pin and a 2-bit logic-family select.

Top module: `clkdist_ctrl`

## Requirements
- R1: After reset, every stored register bit is 0. ch_pd and ch_en are all 0, deep_sleep and hf_rx_sel are 0, and every channel decodes mode 000.
- R2: A write to PD_ADDR stores the power-down word. Bits [NUM_CH-1:0] appear on ch_pd (bit i drives channel i), and bit HFRX_BIT appears on hf_rx_sel. Both outputs follow from the clock edge that takes the write.
- R3: deep_sleep is 1 exactly when all NUM_CH bits of ch_pd are 1.
- R4: A write to EN_ADDR stores bits [NUM_CH-1:0] without changing ch_en. ch_en takes the stored value on the clock edge that samples align_pulse high, and it holds its value on every other edge.
- R5: All channels whose stored enable differs from ch_en change on the same clock edge.
- R6: A write to MODE_BASE+i stores bits [2:0] as the mode of channel i. The mode decodes as follows, giving {p_oe, n_oe, family}. 000 gives {1,1,00}. 001 gives {1,0,00}. 010 gives {0,1,00}. 011 gives {0,0,00}. 100 gives {1,1,01}. 101 gives {1,1,10}. The family codes are 00 = single-ended CMOS, 01 = LVDS, 10 = LVPECL and 11 = off.
- R7: The unused mode codes 110 and 111 decode to {0,0,11}, with both pins undriven.
- R8: reg_rdata returns the stored contents of the addressed register. Bits that are not implemented read 0, and an unmapped address reads 0.
- R9: A write to an unmapped address changes no stored register and no output.
- R10: When a write to EN_ADDR and align_pulse fall on the same edge, ch_en takes the value stored before that write. The new value is applied at the following alignment pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| align_pulse | input | 1 | Common alignment pulse from the divider bank |
| ch_pd | output | NUM_CH | Per-channel power-down |
| ch_en | output | NUM_CH | Per-channel aligned enable |
| ch_p_oe | output | NUM_CH | Positive pin drive enable |
| ch_n_oe | output | NUM_CH | Negative pin drive enable |
| ch_fam | output | 2*NUM_CH | Per-channel family select, 2 bits per channel |
| deep_sleep | output | 1 | All channels powered down |
| hf_rx_sel | output | 1 | High-frequency input receiver select |

## Verification
If a stored register bit is wrong, it shows on the next read of that address and on the decoded pin or power-down lines one cycle after the write. A fault in the enable staging shows in one of two ways: ch_en moves between alignment pulses, or ch_en fails to match the stored word on the edge that samples the pulse. Either fault is visible within one cycle of that pulse. A wrong decode table entry shows as soon as that mode code is stored, so the bench walks every code on every channel.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

   localparam int unsigned MODE_W = 3;

   typedef enum logic [1:0] {
      FAM_CMOS   = 2'b00,
      FAM_LVDS   = 2'b01,
      FAM_LVPECL = 2'b10,
      FAM_OFF    = 2'b11
   } fam_e;

   typedef struct packed {
      logic p_oe;
      logic n_oe;
      fam_e fam;
   } pin_ctl_t;

   function automatic pin_ctl_t decode_mode(input logic [MODE_W-1:0] code);
      pin_ctl_t c;
      c.fam  = FAM_CMOS;
      c.p_oe = 1'b0;
      c.n_oe = 1'b0;
      case (code)
         3'b000: begin c.p_oe = 1'b1; c.n_oe = 1'b1; end
         3'b001: c.p_oe = 1'b1;
         3'b010: c.n_oe = 1'b1;
         3'b011: ;
         3'b100: begin c.p_oe = 1'b1; c.n_oe = 1'b1; c.fam = FAM_LVDS; end
         3'b101: begin c.p_oe = 1'b1; c.n_oe = 1'b1; c.fam = FAM_LVPECL; end
         default: c.fam = FAM_OFF;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/clkdist_regs.sv
module clkdist_regs
   import clkdist_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PD_ADDR   = 'h20,
   parameter int unsigned EN_ADDR   = 'h21,
   parameter int unsigned MODE_BASE = 'h28,
   parameter int unsigned HFRX_BIT  = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic [NUM_CH-1:0]        pd_bits,
   output logic                     hfrx_bit,
   output logic [NUM_CH-1:0]        en_bits,
   output logic [NUM_CH*MODE_W-1:0] mode_flat
);

   localparam logic [ADDR_W-1:0] PD_A = ADDR_W'(PD_ADDR);
   localparam logic [ADDR_W-1:0] EN_A = ADDR_W'(EN_ADDR);

   logic              pd_hit;
   logic              en_hit;
   logic [NUM_CH-1:0] mode_hit;
   logic              any_hit;

   logic [NUM_CH-1:0] pd_q;
   logic              hf_q;
   logic [NUM_CH-1:0] en_q;
   logic [MODE_W-1:0] mode_q [NUM_CH];

   assign pd_hit  = (reg_addr == PD_A);
   assign en_hit  = (reg_addr == EN_A);
   assign any_hit = pd_hit | en_hit | (|mode_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q <= '0;
         hf_q <= 1'b0;
      end else if (reg_wr && pd_hit) begin
         pd_q <= reg_wdata[NUM_CH-1:0];
         hf_q <= reg_wdata[HFRX_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (reg_wr && en_hit) begin
         en_q <= reg_wdata[NUM_CH-1:0];
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_mode
      assign mode_hit[i] = (reg_addr == ADDR_W'(MODE_BASE + i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[i] <= '0;
         end else if (reg_wr && mode_hit[i]) begin
            mode_q[i] <= reg_wdata[MODE_W-1:0];
         end
      end

      assign mode_flat[i*MODE_W +: MODE_W] = mode_q[i];
   end

   always_comb begin
      reg_rdata = '0;
      if (pd_hit) begin
         reg_rdata[NUM_CH-1:0] = pd_q;
         reg_rdata[HFRX_BIT]   = hf_q;
      end
      if (en_hit) begin
         reg_rdata[NUM_CH-1:0] = en_q;
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (mode_hit[i]) begin
            reg_rdata[MODE_W-1:0] = mode_q[i];
         end
      end
   end

   assign pd_bits  = pd_q;
   assign hfrx_bit = hf_q;
   assign en_bits  = en_q;

   AST_PD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && pd_hit) |=> (pd_bits == $past(reg_wdata[NUM_CH-1:0]))); // R2

   AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !any_hit) |=> ($stable(pd_bits) && $stable(en_bits) && $stable(mode_flat) && $stable(hfrx_bit))); // R9

endmodule

// File: rtl/clkdist_en_sync.sv
module clkdist_en_sync #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              align,
   input  logic [NUM_CH-1:0] en_req,
   output logic [NUM_CH-1:0] en_act
);

   logic [NUM_CH-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (align) begin
         act_q <= en_req;
      end
   end

   assign en_act = act_q;

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !align |=> $stable(en_act)); // R4

   AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      align |=> (en_act == $past(en_req))); // R5

endmodule

// File: rtl/clkdist_mode_dec.sv
module clkdist_mode_dec
   import clkdist_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   output logic              p_oe,
   output logic              n_oe,
   output logic [1:0]        fam
);

   pin_ctl_t dec;
   pin_ctl_t ctl;

   assign dec = decode_mode(mode);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl <= decode_mode('0);
         end else begin
            ctl <= dec;
         end
      end
   end else begin : g_comb
      assign ctl = dec;
   end

   assign p_oe = ctl.p_oe;
   assign n_oe = ctl.n_oe;
   assign fam  = ctl.fam;

   AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (fam == FAM_OFF) |-> (!p_oe && !n_oe)); // R7

   AST_DIFF_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      ((fam == FAM_LVDS) || (fam == FAM_LVPECL)) |-> (p_oe && n_oe)); // R6

endmodule

// File: rtl/clkdist_ctrl.sv
module clkdist_ctrl
   import clkdist_pkg::*;
#(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PD_ADDR   = 'h20,
   parameter int unsigned EN_ADDR   = 'h21,
   parameter int unsigned MODE_BASE = 'h28,
   parameter int unsigned HFRX_BIT  = 7,
   parameter bit          DEC_REG   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                align_pulse,
   output logic [NUM_CH-1:0]   ch_pd,
   output logic [NUM_CH-1:0]   ch_en,
   output logic [NUM_CH-1:0]   ch_p_oe,
   output logic [NUM_CH-1:0]   ch_n_oe,
   output logic [2*NUM_CH-1:0] ch_fam,
   output logic                deep_sleep,
   output logic                hf_rx_sel
);

   localparam int unsigned MODE_END = MODE_BASE + NUM_CH;

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
      $error("channel count must fit in one data word");
   end
   if (HFRX_BIT < NUM_CH || HFRX_BIT >= DATA_W) begin : g_bad_hf
      $error("receiver select bit overlaps channels or exceeds the word");
   end
   if (DATA_W < MODE_W) begin : g_bad_dw
      $error("data word too narrow for a mode code");
   end
   if (PD_ADDR == EN_ADDR) begin : g_bad_a0
      $error("power-down and enable addresses collide");
   end
   if ((PD_ADDR >= MODE_BASE && PD_ADDR < MODE_END) ||
       (EN_ADDR >= MODE_BASE && EN_ADDR < MODE_END)) begin : g_bad_a1
      $error("mode window overlaps a control address");
   end
   if (MODE_END > (1 << ADDR_W)) begin : g_bad_a2
      $error("mode window exceeds address space");
   end

   logic [NUM_CH-1:0]        pd_bits;
   logic [NUM_CH-1:0]        en_bits;
   logic [NUM_CH*MODE_W-1:0] mode_flat;

   clkdist_regs #(
      .NUM_CH    (NUM_CH),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PD_ADDR   (PD_ADDR),
      .EN_ADDR   (EN_ADDR),
      .MODE_BASE (MODE_BASE),
      .HFRX_BIT  (HFRX_BIT)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pd_bits   (pd_bits),
      .hfrx_bit  (hf_rx_sel),
      .en_bits   (en_bits),
      .mode_flat (mode_flat)
   );

   clkdist_en_sync #(
      .NUM_CH (NUM_CH)
   ) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .align  (align_pulse),
      .en_req (en_bits),
      .en_act (ch_en)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      clkdist_mode_dec #(
         .REG_OUT (DEC_REG)
      ) dec_i (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (mode_flat[i*MODE_W +: MODE_W]),
         .p_oe  (ch_p_oe[i]),
         .n_oe  (ch_n_oe[i]),
         .fam   (ch_fam[2*i +: 2])
      );
   end

   assign ch_pd      = pd_bits;
   assign deep_sleep = &pd_bits;

   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(PD_ADDR) && (&reg_wdata[NUM_CH-1:0])) |=> deep_sleep); // R3

   AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      deep_sleep |-> ($countones(ch_pd) == NUM_CH)); // R3

endmodule

// File: tb/clkdist_ctrl_tb_top.sv
module clkdist_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int AW  = 8;
   localparam int DW  = 8;
   localparam int PDA = 'h20;
   localparam int ENA = 'h21;
   localparam int MB  = 'h28;
   localparam int HFB = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          align_pulse = 1'b0;
   logic [N-1:0]  ch_pd, ch_en, ch_p_oe, ch_n_oe;
   logic [2*N-1:0] ch_fam;
   logic          deep_sleep, hf_rx_sel;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clkdist_ctrl #(
      .NUM_CH(N), .ADDR_W(AW), .DATA_W(DW), .PD_ADDR(PDA),
      .EN_ADDR(ENA), .MODE_BASE(MB), .HFRX_BIT(HFB), .DEC_REG(1'b0)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .align_pulse(align_pulse),
      .ch_pd(ch_pd), .ch_en(ch_en), .ch_p_oe(ch_p_oe), .ch_n_oe(ch_n_oe),
      .ch_fam(ch_fam), .deep_sleep(deep_sleep), .hf_rx_sel(hf_rx_sel)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 d = int'(reg_rdata);
   endtask

   task automatic pulse_align();
      @(negedge clk);
      align_pulse = 1'b1;
      @(negedge clk);
      align_pulse = 1'b0;
   endtask

   function automatic int exp_ctl(input int m);
      int p, n, f;
      p = (m == 0 || m == 1 || m == 4 || m == 5) ? 1 : 0;
      n = (m == 0 || m == 2 || m == 4 || m == 5) ? 1 : 0;
      f = (m < 4) ? 0 : (m == 4) ? 1 : (m == 5) ? 2 : 3;
      return (p << 3) | (n << 2) | f;
   endfunction

   function automatic int act_ctl(input int ch);
      return (int'(ch_p_oe[ch]) << 3) | (int'(ch_n_oe[ch]) << 2) | int'(ch_fam[2*ch +: 2]);
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      int v;
      int prev;
      int snap [0:5];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ch_pd", int'(ch_pd), 0);
      check("R1 ch_en", int'(ch_en), 0);
      check("R1 deep_sleep", int'(deep_sleep), 0);
      check("R1 hf_rx_sel", int'(hf_rx_sel), 0);
      for (int c = 0; c < N; c++) check("R1 mode decode", act_ctl(c), exp_ctl(0));

      // R2 R3 R8: all power-down patterns with receiver select toggled
      for (int p = 0; p < 32; p++) begin
         wr(PDA, (p & 15) | (((p >> 4) & 1) << HFB) | 'h30);
         check("R2 ch_pd", int'(ch_pd), p & 15);
         check("R2 hf_rx_sel", int'(hf_rx_sel), (p >> 4) & 1);
         check("R3 deep_sleep", int'(deep_sleep), ((p & 15) == 15) ? 1 : 0);
         rd(PDA, v);
         check("R8 pd readback", v, (p & 15) | (((p >> 4) & 1) << HFB));
      end
      wr(PDA, 0);

      // R4 R5 R8: every enable pattern, held until alignment
      prev = 0;
      for (int e = 1; e <= 16; e++) begin
         wr(ENA, (e & 15) | 'hF0);
         check("R4 held before align", int'(ch_en), prev);
         rd(ENA, v);
         check("R8 en readback", v, e & 15);
         repeat (3) @(negedge clk);
         check("R4 still held", int'(ch_en), prev);
         pulse_align();
         check("R5 applied together", int'(ch_en), e & 15);
         prev = e & 15;
      end

      // R10 write and align on the same edge
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AW'(ENA); reg_wdata = 8'h0A; align_pulse = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; align_pulse = 1'b0;
      check("R10 old value used", int'(ch_en), prev);
      pulse_align();
      check("R10 new value next pulse", int'(ch_en), 'hA);

      // R6 R7 R8: every code on every channel
      for (int c = 0; c < N; c++) begin
         for (int m = 0; m < 8; m++) begin
            wr(MB + c, m | 'hF8);
            if (m >= 6) check("R7 unused code", act_ctl(c), exp_ctl(m));
            else        check("R6 decode", act_ctl(c), exp_ctl(m));
            rd(MB + c, v);
            check("R8 mode readback", v, m);
         end
         wr(MB + c, c + 1);
      end
      for (int c = 0; c < N; c++) check("R6 channels independent", act_ctl(c), exp_ctl(c + 1));

      // R9 unmapped writes, R8 unmapped reads
      wr(PDA, 'h85);
      wr(ENA, 'h06);
      for (int i = 0; i < 4; i++) begin rd(MB + i, v); snap[i] = v; end
      rd(PDA, v); snap[4] = v;
      rd(ENA, v); snap[5] = v;
      for (int a = 'h22; a < MB; a++) begin
         wr(a, 'hFF);
         rd(a, v);
         check("R8 unmapped read", v, 0);
      end
      wr(MB + N, 'hFF);
      wr('hFF, 'hFF);
      for (int i = 0; i < 4; i++) begin
         rd(MB + i, v);
         check("R9 mode untouched", v, snap[i]);
      end
      rd(PDA, v); check("R9 pd untouched", v, snap[4]);
      rd(ENA, v); check("R9 en untouched", v, snap[5]);
      check("R9 ch_pd", int'(ch_pd), 5);
      check("R9 hf_rx_sel", int'(hf_rx_sel), 1);
      check("R9 ch_en", int'(ch_en), 'hA);
      pulse_align();
      check("R4 applied after R9", int'(ch_en), 6);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule